// File: doc/BRIEF.md
# Indirect interrupt-line configuration window

This block holds the configuration of a table of shared interrupt lines and exposes it to software through a small select-then-access window. Each requester carries a domain tag on every register access. Each domain owns a private selector register that names one line; the configuration, ownership and status registers then operate on whichever line the requesting domain's selector names. Per line the block stores a trigger-mode bit and a 2-bit owning-domain field.

Access through the window is gated by ownership. A selection counts as valid only when the selector names an implemented line and the requester either owns that line or is the most-privileged domain (code 3). Invalid selections read as zero and silently drop writes. Only the most-privileged domain can see or change which domain owns a line; for every other domain the ownership register reads zero and ignores writes. Writes take effect immediately, so the status register always reports idle.

The register port has four register codes on `req_reg`: 0 selector, 1 configuration, 2 ownership, 3 status. Reads return data one cycle after they are issued.

Top module: `irq_cfg_window`

## Requirements
- R1: Each of the four domains has its own selector; a selector write stores the full data word, and a selector read (register code 0) returns the word last written by the same domain, unaffected by other domains' writes.
- R2: A selection is valid only when the selector value is below the line count (64; any value of 64 or more is unimplemented) and either the requesting domain is 3 or the selected line's owner equals the requesting domain. The line ID is selector bits [5:0].
- R3: A status read (register code 3) returns bit 1 set exactly when the requesting domain's current selection is valid.
- R4: A status read always returns bit 0 (idle) as 1; all status bits above bit 1 read 0.
- R5: A configuration read (register code 1) returns the selected line's trigger-mode bit in bit 0 when the selection is valid, and 0 otherwise; all other bits read 0.
- R6: A configuration write updates the selected line's trigger-mode bit from data bit 0 only when the selection is valid; otherwise the line is unchanged.
- R7: For domains 0, 1 and 2 the ownership register (register code 2) reads 0 and writes to it change nothing.
- R8: For domain 3 with a valid selection, an ownership read returns the line's owner in bits [1:0] and an ownership write sets the owner from data bits [1:0].
- R9: After reset all selectors read 0, all trigger-mode bits are 0 and every line is owned by domain 3.
- R10: `rd_valid` pulses in the cycle after a read is issued and stays low after writes and idle cycles; a write is visible to a read issued in the very next cycle from any domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_dom | input | DOM_W | Domain tag of the requester (3 is most privileged) |
| req_reg | input | 2 | Register code: 0 selector, 1 configuration, 2 ownership, 3 status |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block with its defaults: a 32-bit data word, 64 lines and four domains. With 64 lines the boundary between line 63 and the unimplemented ID 64 is reachable with single writes, and the full 32-bit selector lets a value such as 70 probe out-of-range IDs whose low six bits alias an implemented line. Four domains make both owner mismatch and the privileged override observable, and ownership handover from domain 3 to another domain can be followed end to end.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_CFG  = 2'd1,
    REG_OWN  = 2'd2,
    REG_STAT = 2'd3
  } reg_e;

  localparam int CFG_TM_BIT    = 0;
  localparam int STAT_IDLE_BIT = 0;
  localparam int STAT_OK_BIT   = 1;

endpackage

// File: rtl/irqw_sel_bank.sv
module irqw_sel_bank #(
  parameter int DATA_W = 32,
  parameter int DOM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DOM_W-1:0]  dom,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sel_out
);
  localparam int NUM_DOM = 1 << DOM_W;

  logic [DATA_W-1:0] sel_q [NUM_DOM];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[d] <= '0;
      end else if (wr_en && dom == DOM_W'(d)) begin
        sel_q[d] <= wr_data;
      end
    end
  end

  assign sel_out = sel_q[dom];
endmodule

// File: rtl/irqw_access_check.sv
module irqw_access_check #(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int DOM_W     = 2,
  parameter int ID_W      = 6
) (
  input  logic [DATA_W-1:0] cur_sel,
  input  logic [DOM_W-1:0]  dom,
  input  logic [DOM_W-1:0]  line_owner,
  output logic [ID_W-1:0]   line_id,
  output logic              is_priv,
  output logic              sel_ok
);
  localparam logic [DOM_W-1:0]  PRIV_DOM  = '1;
  localparam logic [DATA_W-1:0] LINE_LIM  = DATA_W'(NUM_LINES);

  logic in_range;

  always_comb begin
    line_id  = cur_sel[ID_W-1:0];
    in_range = cur_sel < LINE_LIM;
    is_priv  = dom == PRIV_DOM;
    sel_ok   = in_range && (is_priv || line_owner == dom);
  end
endmodule

// File: rtl/irqw_line_table.sv
module irqw_line_table #(
  parameter int NUM_LINES = 64,
  parameter int DOM_W     = 2,
  parameter int ID_W      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  line_id,
  input  logic             tm_we,
  input  logic             tm_wd,
  input  logic             own_we,
  input  logic [DOM_W-1:0] own_wd,
  output logic             tm_rd,
  output logic [DOM_W-1:0] own_rd
);
  logic             tm_q  [NUM_LINES];
  logic [DOM_W-1:0] own_q [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        tm_q[i]  <= 1'b0;
        own_q[i] <= '1;
      end else if (line_id == ID_W'(i)) begin
        if (tm_we)  tm_q[i]  <= tm_wd;
        if (own_we) own_q[i] <= own_wd;
      end
    end
  end

  always_comb begin
    tm_rd  = 1'b0;
    own_rd = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (line_id == ID_W'(i)) begin
        tm_rd  = tm_q[i];
        own_rd = own_q[i];
      end
    end
  end
endmodule

// File: rtl/irq_cfg_window.sv
module irq_cfg_window #(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int DOM_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DOM_W-1:0]  req_dom,
  input  logic [1:0]        req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import irqw_pkg::*;

  localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  reg_e              kind;
  logic [DATA_W-1:0] cur_sel;
  logic [ID_W-1:0]   line_id;
  logic [DOM_W-1:0]  line_owner;
  logic              line_tm;
  logic              is_priv;
  logic              sel_ok;
  logic              do_wr;
  logic              do_rd;
  logic              sel_we;
  logic              tm_we;
  logic              own_we;
  logic [DATA_W-1:0] rd_next;

  assign kind   = reg_e'(req_reg);
  assign do_wr  = req_valid && req_write;
  assign do_rd  = req_valid && !req_write;
  assign sel_we = do_wr && kind == REG_SEL;
  assign tm_we  = do_wr && kind == REG_CFG && sel_ok;
  assign own_we = do_wr && kind == REG_OWN && sel_ok && is_priv;

  irqw_sel_bank #(.DATA_W(DATA_W), .DOM_W(DOM_W)) sel_bank_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (sel_we),
    .dom     (req_dom),
    .wr_data (req_wdata),
    .sel_out (cur_sel)
  );

  irqw_access_check #(
    .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .DOM_W(DOM_W), .ID_W(ID_W)
  ) access_i (
    .cur_sel    (cur_sel),
    .dom        (req_dom),
    .line_owner (line_owner),
    .line_id    (line_id),
    .is_priv    (is_priv),
    .sel_ok     (sel_ok)
  );

  irqw_line_table #(.NUM_LINES(NUM_LINES), .DOM_W(DOM_W), .ID_W(ID_W)) table_i (
    .clk     (clk),
    .rst     (rst),
    .line_id (line_id),
    .tm_we   (tm_we),
    .tm_wd   (req_wdata[CFG_TM_BIT]),
    .own_we  (own_we),
    .own_wd  (req_wdata[DOM_W-1:0]),
    .tm_rd   (line_tm),
    .own_rd  (line_owner)
  );

  always_comb begin
    rd_next = '0;
    unique case (kind)
      REG_SEL: rd_next = cur_sel;
      REG_CFG: rd_next[CFG_TM_BIT] = sel_ok && line_tm;
      REG_OWN: if (is_priv && sel_ok) rd_next[DOM_W-1:0] = line_owner;
      REG_STAT: begin
        rd_next[STAT_IDLE_BIT] = 1'b1;
        rd_next[STAT_OK_BIT]   = sel_ok;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/irq_cfg_window_chk.sv
module irq_cfg_window_chk #(
  parameter int DATA_W = 32,
  parameter int DOM_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [DOM_W-1:0]  req_dom,
  input logic [1:0]        req_reg,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  localparam logic [DOM_W-1:0] PRIV_DOM = '1;

  // R10: a read is answered in the following cycle
  p_read_answers_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  // R10: nothing but a read produces a response
  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  // R4: idle is always reported and high status bits stay zero
  p_status_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_reg) == 2'd3)
      |-> (rd_data[0] && rd_data[DATA_W-1:2] == '0));

  // R5: configuration reads carry only the trigger-mode bit
  p_cfg_narrow_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_reg) == 2'd1) |-> rd_data[DATA_W-1:1] == '0);

  // R7: ownership reads from a non-privileged domain are zero
  p_own_hidden_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_reg) == 2'd2 && $past(req_dom) != PRIV_DOM)
      |-> rd_data == '0);
endmodule

bind irq_cfg_window irq_cfg_window_chk #(.DATA_W(DATA_W), .DOM_W(DOM_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_dom   (req_dom),
  .req_reg   (req_reg),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/irq_cfg_window_tb_top.sv
module irq_cfg_window_tb_top;
  localparam int DW = 32;

  // register codes
  localparam logic [1:0] SEL = 2'd0, CFG = 2'd1, OWN = 2'd2, STA = 2'd3;
  // vector layout: req(4) wr(1) dom(2) reg(2) wdata(32) chk(1) exp(32)
  localparam int VW = 74;
  localparam int NV = 38;
  localparam logic W = 1'b1, R = 1'b0;

  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd9,  R, 2'd0, SEL, 32'd0,          1'b1, 32'd0},  // R9 selector cleared
    {4'd3,  R, 2'd3, STA, 32'd0,          1'b1, 32'd3},  // R3 priv valid on line 0
    {4'd2,  R, 2'd0, STA, 32'd0,          1'b1, 32'd1},  // R2 dom0 does not own line 0
    {4'd9,  R, 2'd3, OWN, 32'd0,          1'b1, 32'd3},  // R9 owner is domain 3
    {4'd9,  R, 2'd3, CFG, 32'd0,          1'b1, 32'd0},  // R9 trigger mode cleared
    {4'd8,  W, 2'd3, OWN, 32'd1,          1'b0, 32'd0},  // R8 hand line 0 to dom1
    {4'd8,  R, 2'd3, OWN, 32'd0,          1'b1, 32'd1},  // R8
    {4'd2,  R, 2'd1, STA, 32'd0,          1'b1, 32'd3},  // R2 dom1 now owns line 0
    {4'd6,  W, 2'd1, CFG, 32'hFFFF_FFFF,  1'b0, 32'd0},  // R6 owner sets tm
    {4'd5,  R, 2'd1, CFG, 32'd0,          1'b1, 32'd1},  // R5
    {4'd5,  R, 2'd0, CFG, 32'd0,          1'b1, 32'd0},  // R5 invalid reads zero
    {4'd6,  W, 2'd0, CFG, 32'd0,          1'b0, 32'd0},  // R6 dropped write
    {4'd6,  R, 2'd1, CFG, 32'd0,          1'b1, 32'd1},  // R6 still set
    {4'd5,  R, 2'd3, CFG, 32'd0,          1'b1, 32'd1},  // R5 priv sees tm
    {4'd1,  W, 2'd2, SEL, 32'd64,         1'b0, 32'd0},  // R1
    {4'd1,  R, 2'd2, SEL, 32'd0,          1'b1, 32'd64}, // R1 readback
    {4'd2,  R, 2'd2, STA, 32'd0,          1'b1, 32'd1},  // R2 ID 64 unimplemented
    {4'd2,  W, 2'd3, SEL, 32'd70,         1'b0, 32'd0},  // R2 low bits alias line 6
    {4'd2,  R, 2'd3, STA, 32'd0,          1'b1, 32'd1},  // R2 priv still invalid
    {4'd5,  R, 2'd3, CFG, 32'd0,          1'b1, 32'd0},  // R5 invalid
    {4'd8,  R, 2'd3, OWN, 32'd0,          1'b1, 32'd0},  // R8 invalid reads zero
    {4'd7,  W, 2'd1, OWN, 32'd2,          1'b0, 32'd0},  // R7 ignored
    {4'd7,  R, 2'd1, OWN, 32'd0,          1'b1, 32'd0},  // R7 reads zero
    {4'd1,  W, 2'd3, SEL, 32'd0,          1'b0, 32'd0},  // R1
    {4'd7,  R, 2'd3, OWN, 32'd0,          1'b1, 32'd1},  // R7 owner unchanged
    {4'd1,  R, 2'd2, SEL, 32'd0,          1'b1, 32'd64}, // R1 dom2 independent
    {4'd1,  W, 2'd3, SEL, 32'd63,         1'b0, 32'd0},  // R1 last line
    {4'd2,  R, 2'd3, STA, 32'd0,          1'b1, 32'd3},  // R2 line 63 implemented
    {4'd6,  W, 2'd3, CFG, 32'd1,          1'b0, 32'd0},  // R6 priv override
    {4'd5,  R, 2'd3, CFG, 32'd0,          1'b1, 32'd1},  // R5
    {4'd8,  W, 2'd3, OWN, 32'hFFFF_FFFE,  1'b0, 32'd0},  // R8 owner from bits [1:0]
    {4'd8,  R, 2'd3, OWN, 32'd0,          1'b1, 32'd2},  // R8
    {4'd1,  W, 2'd2, SEL, 32'd63,         1'b0, 32'd0},  // R1
    {4'd3,  R, 2'd2, STA, 32'd0,          1'b1, 32'd3},  // R3 dom2 owns line 63
    {4'd5,  R, 2'd2, CFG, 32'd0,          1'b1, 32'd1},  // R5
    {4'd6,  W, 2'd2, CFG, 32'd0,          1'b0, 32'd0},  // R6 owner clears tm
    {4'd6,  R, 2'd3, CFG, 32'd0,          1'b1, 32'd0},  // R6 seen by priv
    {4'd3,  R, 2'd1, STA, 32'd0,          1'b1, 32'd3}   // R3 dom1 line 0 still valid
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_dom = '0;
  logic [1:0]    req_reg = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_cfg_window dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_dom   (req_dom),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access; read data sampled at the negedge after the capturing edge
  task automatic access(input logic wr, input logic [1:0] d, input logic [1:0] r,
                        input logic [DW-1:0] wd, output logic v, output logic [DW-1:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dom = d; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    v = rd_valid; q = rd_data;
  endtask

  initial begin
    logic          v;
    logic [DW-1:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d vec%0d", e[73:70], i);
      access(e[69], e[68:67], e[66:65], e[64:33], v, q);
      if (e[69]) check({tag, " R10 no rsp"}, {31'd0, v}, 32'd0);
      else begin
        check({tag, " R10 rsp"}, {31'd0, v}, 32'd1);
        if (e[32]) check(tag, q, e[31:0]);
      end
    end

    // R10: back-to-back write then read from another domain
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_dom = 2'd2; req_reg = CFG; req_wdata = 32'd1;
    @(negedge clk);
    req_write = 1'b0; req_dom = 2'd3; req_reg = CFG;
    check("R10 no rsp after write", {31'd0, rd_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp valid", {31'd0, rd_valid}, 32'd1);
    check("R10 write visible next cycle", rd_data, 32'd1);
    @(negedge clk);
    check("R10 idle no rsp", {31'd0, rd_valid}, 32'd0);

    // R9: reset in mid-run restores defaults
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    rst = 1'b0;
    access(R, 2'd2, SEL, '0, v, q);  check("R9 sel cleared", q, 32'd0);
    access(W, 2'd3, SEL, 32'd63, v, q);
    access(R, 2'd3, OWN, '0, v, q);  check("R9 owner back to 3", q, 32'd3);
    access(R, 2'd3, CFG, '0, v, q);  check("R9 tm cleared", q, 32'd0);
    access(W, 2'd2, SEL, 32'd63, v, q);
    access(R, 2'd2, STA, '0, v, q);  check("R2 dom2 lost line after reset", q, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule